// File: doc/BRIEF.md
# Receive Endpoint Descriptor Completion Engine

This block owns the transfer descriptor that is currently in use on one receive (OUT) endpoint. Software, or a fetch unit acting for it, writes a descriptor through the load port. The descriptor carries an active flag, the total bytes expected, a link to the following descriptor and a flag marking it as the last in the chain. When the receive data path finishes a packet, it strobes the block with the packet's byte count. The block compares that count with the endpoint's maximum packet size and with the bytes still outstanding, and sorts the packet into one of three kinds. A short packet completes the transfer. A full-size packet continues it. An oversized packet, or one that overruns the descriptor, is an error.

After a completion the descriptor is retired. The block then either requests the linked descriptor or, when the chain ends, flushes the endpoint and goes idle. After an error it marks the descriptor with a buffer-error flag, flushes the endpoint and halts on the failed descriptor. It stays halted until a new descriptor is loaded. Packets that failed at the link level are retried upstream and never touch descriptor state.

Top module: `rxd_cmpl_eng`

## Requirements
- R1: While reset is asserted and after it is released, every output is zero: not primed, descriptor inactive, count zero, no error flag, no pulses.
- R2: A load strobe captures the descriptor in one cycle. The descriptor and `primed` follow the loaded active flag, and `buf_err` is cleared. A load in the same cycle as a packet strobe wins, and that packet is dropped.
- R3: A packet whose byte count equals `max_pkt` and leaves bytes outstanding reduces `remaining` by that count. The descriptor stays primed and no pulse is raised.
- R4: A packet shorter than `max_pkt` (and no larger than `remaining`) reduces `remaining` by its size and clears the active flag. It raises `int_done` for exactly one cycle, in the cycle after the packet strobe. The leftover count stays readable.
- R5: A full-size packet that brings `remaining` to exactly zero completes the descriptor in the same way as a short packet.
- R6: On completion with the end-of-chain flag clear, `fetch_req` pulses together with `int_done`, `fetch_ptr` shows the stored link, and `flush` stays low.
- R7: On completion with the end-of-chain flag set, `flush` pulses together with `int_done` and no fetch is requested.
- R8: A packet larger than `max_pkt` sets `buf_err` and leaves `remaining` unchanged. `desc_active` stays high and `primed` drops. `int_err` and `flush` pulse for one cycle, and `int_done` does not.
- R9: A packet no larger than `max_pkt` but larger than `remaining` is handled exactly as in R8.
- R10: After an error the block stays halted on the failed descriptor and ignores packet strobes until a new load re-arms it.
- R11: A packet strobe with `pkt_fault` high changes no state and raises no pulse.
- R12: A packet strobe while not primed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_active | input | 1 | Active flag of the loaded descriptor |
| ld_term | input | 1 | End-of-chain flag of the loaded descriptor |
| ld_total | input | CNT_W | Total bytes of the loaded descriptor |
| ld_next | input | PTR_W | Link to the following descriptor |
| max_pkt | input | MPS_W | Endpoint maximum packet size in bytes |
| pkt_done | input | 1 | Packet finished strobe |
| pkt_fault | input | 1 | Packet failed at link level (retried, ignored here) |
| pkt_bytes | input | MPS_W+1 | Byte count of the finished packet |
| primed | output | 1 | Active descriptor loaded and not halted |
| desc_active | output | 1 | Active flag of the held descriptor |
| remaining | output | CNT_W | Bytes still outstanding in the descriptor |
| buf_err | output | 1 | Buffer-error flag of the held descriptor |
| fetch_req | output | 1 | One-cycle request to fetch the linked descriptor |
| fetch_ptr | output | PTR_W | Link of the held descriptor |
| flush | output | 1 | One-cycle endpoint flush pulse |
| int_done | output | 1 | One-cycle completion interrupt |
| int_err | output | 1 | One-cycle error interrupt |

## Verification
The bench targets the boundaries between packet kinds.
- A packet of exactly `max_pkt` bytes must continue the transfer. A design using the wrong comparison would retire the descriptor early or flag an error.
- A full-size packet that drains the count to zero must complete. A design missing this would hang primed with nothing left to receive.
- A packet that fits `max_pkt` but overruns `remaining` must raise the error. A design missing this would wrap the count.

The bench also sends packets while halted, marked faulty, and in the same cycle as a load. A design that let any of these through would change the count or raise stray pulses.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    PK_SHORT = 2'd0,
    PK_FULL  = 2'd1,
    PK_LONG  = 2'd2
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HALT  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/rxd_classify.sv
module rxd_classify
  import rxd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int MPS_W = 11
) (
  input  logic [MPS_W:0]   pkt_bytes,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic [CNT_W-1:0] remaining,
  output pkt_kind_e        kind,
  output logic [CNT_W-1:0] rem_after,
  output logic             completes
);
  localparam int PKT_W = MPS_W + 1;

  logic [CNT_W-1:0] bytes_ext;
  logic [PKT_W-1:0] max_ext;
  logic             over_max;
  logic             over_rem;

  always_comb begin
    bytes_ext = CNT_W'(pkt_bytes);
    max_ext   = PKT_W'(max_pkt);
    over_max  = pkt_bytes > max_ext;
    over_rem  = bytes_ext > remaining;
    rem_after = remaining - bytes_ext;
    if (over_max || over_rem) begin
      kind = PK_LONG;
    end else if (pkt_bytes < max_ext) begin
      kind = PK_SHORT;
    end else begin
      kind = PK_FULL;
    end
    completes = (kind == PK_SHORT) || ((kind == PK_FULL) && (rem_after == '0));
  end
endmodule

// File: rtl/rxd_desc_store.sv
module rxd_desc_store #(
  parameter int CNT_W = 16,
  parameter int PTR_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_active,
  input  logic             ld_term,
  input  logic [CNT_W-1:0] ld_total,
  input  logic [PTR_W-1:0] ld_next,
  input  logic             cnt_upd,
  input  logic [CNT_W-1:0] rem_after,
  input  logic             clr_active,
  input  logic             set_err,
  output logic             active,
  output logic             term,
  output logic             buf_err,
  output logic [CNT_W-1:0] remaining,
  output logic [PTR_W-1:0] next_ptr
);
  logic             active_d;
  logic             buf_err_d;
  logic [CNT_W-1:0] remaining_d;
  logic             desc_en;

  always_comb begin
    desc_en     = ld_valid;
    active_d    = active;
    buf_err_d   = buf_err;
    remaining_d = remaining;
    if (ld_valid) begin
      active_d    = ld_active;
      buf_err_d   = 1'b0;
      remaining_d = ld_total;
    end else begin
      if (cnt_upd)    remaining_d = rem_after;
      if (clr_active) active_d    = 1'b0;
      if (set_err)    buf_err_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      buf_err   <= 1'b0;
      remaining <= '0;
    end else begin
      active    <= active_d;
      buf_err   <= buf_err_d;
      remaining <= remaining_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term     <= 1'b0;
      next_ptr <= '0;
    end else if (desc_en) begin
      term     <= ld_term;
      next_ptr <= ld_next;
    end
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_valid,
  input  logic      ld_active,
  input  logic      pkt_done,
  input  logic      pkt_fault,
  input  pkt_kind_e kind,
  input  logic      completes,
  input  logic      term,
  output logic      primed,
  output logic      cnt_upd,
  output logic      clr_active,
  output logic      set_err,
  output logic      int_done,
  output logic      int_err,
  output logic      flush,
  output logic      fetch_req
);
  eng_state_e state_q, state_d;
  logic accept;
  logic done_d, err_d, flush_d, fetch_d;

  always_comb begin
    accept     = pkt_done && !pkt_fault && !ld_valid && (state_q == ST_ARMED);
    set_err    = accept && (kind == PK_LONG);
    cnt_upd    = accept && (kind != PK_LONG);
    clr_active = cnt_upd && completes;
    done_d     = clr_active;
    err_d      = set_err;
    flush_d    = set_err || (clr_active && term);
    fetch_d    = clr_active && !term;
    state_d    = state_q;
    if (ld_valid) begin
      state_d = ld_active ? ST_ARMED : ST_IDLE;
    end else if (set_err) begin
      state_d = ST_HALT;
    end else if (clr_active) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      int_done  <= 1'b0;
      int_err   <= 1'b0;
      flush     <= 1'b0;
      fetch_req <= 1'b0;
    end else begin
      state_q   <= state_d;
      int_done  <= done_d;
      int_err   <= err_d;
      flush     <= flush_d;
      fetch_req <= fetch_d;
    end
  end

  assign primed = (state_q == ST_ARMED);
endmodule

// File: rtl/rxd_cmpl_eng.sv
module rxd_cmpl_eng
  import rxd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PTR_W = 27,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_active,
  input  logic             ld_term,
  input  logic [CNT_W-1:0] ld_total,
  input  logic [PTR_W-1:0] ld_next,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             pkt_done,
  input  logic             pkt_fault,
  input  logic [MPS_W:0]   pkt_bytes,
  output logic             primed,
  output logic             desc_active,
  output logic [CNT_W-1:0] remaining,
  output logic             buf_err,
  output logic             fetch_req,
  output logic [PTR_W-1:0] fetch_ptr,
  output logic             flush,
  output logic             int_done,
  output logic             int_err
);
  pkt_kind_e        kind;
  logic [CNT_W-1:0] rem_after;
  logic             completes;
  logic             term;
  logic             cnt_upd;
  logic             clr_active;
  logic             set_err;

  rxd_classify #(.CNT_W(CNT_W), .MPS_W(MPS_W)) u_cls (
    .pkt_bytes (pkt_bytes),
    .max_pkt   (max_pkt),
    .remaining (remaining),
    .kind      (kind),
    .rem_after (rem_after),
    .completes (completes)
  );

  rxd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_active  (ld_active),
    .pkt_done   (pkt_done),
    .pkt_fault  (pkt_fault),
    .kind       (kind),
    .completes  (completes),
    .term       (term),
    .primed     (primed),
    .cnt_upd    (cnt_upd),
    .clr_active (clr_active),
    .set_err    (set_err),
    .int_done   (int_done),
    .int_err    (int_err),
    .flush      (flush),
    .fetch_req  (fetch_req)
  );

  rxd_desc_store #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_active  (ld_active),
    .ld_term    (ld_term),
    .ld_total   (ld_total),
    .ld_next    (ld_next),
    .cnt_upd    (cnt_upd),
    .rem_after  (rem_after),
    .clr_active (clr_active),
    .set_err    (set_err),
    .active     (desc_active),
    .term       (term),
    .buf_err    (buf_err),
    .remaining  (remaining),
    .next_ptr   (fetch_ptr)
  );
endmodule

// File: rtl/rxd_cmpl_eng_chk.sv
module rxd_cmpl_eng_chk #(
  parameter int CNT_W = 16,
  parameter int PTR_W = 27,
  parameter int MPS_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             pkt_done,
  input logic             pkt_fault,
  input logic             primed,
  input logic             desc_active,
  input logic [CNT_W-1:0] remaining,
  input logic             buf_err,
  input logic             fetch_req,
  input logic [PTR_W-1:0] fetch_ptr,
  input logic             flush,
  input logic             int_done,
  input logic             int_err
);
  a_r2_primed_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> desc_active);

  a_r8_err_pulse_state: assert property (@(posedge clk) disable iff (!rst_n)
    int_err |-> (buf_err && desc_active && !primed && flush && !int_done));

  a_r6_fetch_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (int_done && !flush && !desc_active));

  a_r3_count_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (remaining <= $past(remaining)));

  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_active && !primed && !ld_valid) |=> (desc_active && !primed && $stable(remaining)));

  a_r11_fault_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && pkt_done && pkt_fault && !ld_valid) |=>
      ($stable(remaining) && primed && !int_done && !int_err));
endmodule

bind rxd_cmpl_eng rxd_cmpl_eng_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W), .MPS_W(MPS_W)) u_chk (.*);

// File: tb/rxd_cmpl_eng_tb_top.sv
module rxd_cmpl_eng_tb_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int PTR_W = 27;
  localparam int MPS_W = 11;

  logic clk, rst_n;
  logic ld_valid, ld_active, ld_term;
  logic [CNT_W-1:0] ld_total;
  logic [PTR_W-1:0] ld_next;
  logic [MPS_W-1:0] max_pkt;
  logic pkt_done, pkt_fault;
  logic [MPS_W:0] pkt_bytes;
  logic primed, desc_active, buf_err, fetch_req, flush, int_done, int_err;
  logic [CNT_W-1:0] remaining;
  logic [PTR_W-1:0] fetch_ptr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  rxd_cmpl_eng #(.CNT_W(CNT_W), .PTR_W(PTR_W), .MPS_W(MPS_W)) dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  bit m_active, m_primed, m_err, m_term;
  bit m_done, m_errp, m_flush, m_fetch;
  int m_rem;
  int m_next;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_primed = 0; m_err = 0; m_term = 0;
      m_done = 0; m_errp = 0; m_flush = 0; m_fetch = 0;
      m_rem = 0; m_next = 0;
    end else begin
      m_done = 0; m_errp = 0; m_flush = 0; m_fetch = 0;
      if (ld_valid) begin
        m_active = ld_active; m_primed = ld_active; m_err = 0;
        m_rem = int'(ld_total); m_next = int'(ld_next); m_term = ld_term;
      end else if (pkt_done && !pkt_fault && m_primed) begin
        if (int'(pkt_bytes) > int'(max_pkt) || int'(pkt_bytes) > m_rem) begin
          m_err = 1; m_primed = 0; m_errp = 1; m_flush = 1;
        end else begin
          m_rem = m_rem - int'(pkt_bytes);
          if (int'(pkt_bytes) < int'(max_pkt) || m_rem == 0) begin
            m_active = 0; m_primed = 0; m_done = 1;
            if (m_term) m_flush = 1; else m_fetch = 1;
          end
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "primed", int'(primed), int'(m_primed));
    chk(cur_req, "desc_active", int'(desc_active), int'(m_active));
    chk(cur_req, "remaining", int'(remaining), m_rem);
    chk(cur_req, "buf_err", int'(buf_err), int'(m_err));
    chk(cur_req, "int_done", int'(int_done), int'(m_done));
    chk(cur_req, "int_err", int'(int_err), int'(m_errp));
    chk(cur_req, "flush", int'(flush), int'(m_flush));
    chk(cur_req, "fetch_req", int'(fetch_req), int'(m_fetch));
    chk(cur_req, "fetch_ptr", int'(fetch_ptr), m_next);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    ld_valid = 0; pkt_done = 0; pkt_fault = 0;
  endtask

  task automatic load(bit act, bit trm, int total, int nxt);
    ld_valid = 1; ld_active = act; ld_term = trm;
    ld_total = CNT_W'(total); ld_next = PTR_W'(nxt);
    tick();
  endtask

  task automatic pkt(int n, bit fault);
    pkt_done = 1; pkt_fault = fault; pkt_bytes = (MPS_W+1)'(n);
    tick();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_valid = 0; ld_active = 0; ld_term = 0; ld_total = '0; ld_next = '0;
    max_pkt = MPS_W'(64); pkt_done = 0; pkt_fault = 0; pkt_bytes = '0;
    cur_req = "R1";
    tick(); tick();
    rst_n = 1;
    tick();

    cur_req = "R2"; load(1, 0, 200, 'h123);
    chk("R2", "primed after load", int'(primed), 1);
    cur_req = "R3"; pkt(64, 0);
    chk("R3", "count after full", int'(remaining), 136);
    pkt(64, 0);
    cur_req = "R11"; pkt(64, 1);
    chk("R11", "count after fault", int'(remaining), 72);
    cur_req = "R4"; pkt(10, 0);
    chk("R4", "int_done pulse", int'(int_done), 1);
    chk("R4", "leftover count", int'(remaining), 62);
    cur_req = "R6";
    chk("R6", "fetch_ptr", int'(fetch_ptr), 'h123);
    tick();
    chk("R4", "pulse one cycle", int'(int_done), 0);

    cur_req = "R12"; pkt(5, 0);
    chk("R12", "idle count", int'(remaining), 62);

    cur_req = "R5"; load(1, 1, 128, 'h55);
    pkt(64, 0); pkt(64, 0);
    cur_req = "R7";
    chk("R7", "flush at end of chain", int'(flush), 1);
    chk("R7", "no fetch", int'(fetch_req), 0);
    tick();

    cur_req = "R8"; load(1, 0, 100, 'h7);
    pkt(65, 0);
    chk("R8", "buf_err", int'(buf_err), 1);
    chk("R8", "count kept", int'(remaining), 100);
    cur_req = "R10"; pkt(10, 0); pkt(64, 0);
    chk("R10", "halted count", int'(remaining), 100);
    load(1, 0, 50, 'h9);
    chk("R10", "rearm clears err", int'(buf_err), 0);
    cur_req = "R9"; pkt(60, 0);
    chk("R9", "overrun error", int'(int_err), 1);
    tick();

    cur_req = "R12";
    ld_valid = 1; ld_active = 1; ld_term = 0; ld_total = CNT_W'(30); ld_next = PTR_W'('h11);
    pkt_done = 1; pkt_bytes = (MPS_W+1)'(20);
    tick();
    chk("R12", "load wins", int'(remaining), 30);
    cur_req = "R4"; pkt(30, 0);
    chk("R4", "exact short to zero", int'(remaining), 0);
    tick();

    cur_req = "R2"; load(0, 0, 40, 'h3);
    chk("R2", "inactive load not primed", int'(primed), 0);
    pkt(8, 0);
    tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule